// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends stereo 24-bit audio samples over a three-wire serial link made of a frame clock, a bit clock and one data line. The data line carries each sample most significant bit first, left channel before right, inside 32-bit half-frames. The bits after the 24th in each half are zero. A format input picks left-justified framing, where the MSB follows the frame-clock transition at once, or I2S framing, where the MSB comes one bit period later and the frame clock is inverted.

In master role the block runs from a system clock taken to be 256 times the sample rate. It divides that clock by 4 to make the bit clock and by 256 to make the frame clock. In slave role it leaves its own clock outputs low. It samples an externally driven bit clock and frame clock into the system clock, steps its bit position on each falling bit-clock edge, and realigns to the start of a half-frame on every frame-clock change. A sample pair is handed over with a valid/ready handshake into a one-deep holding register. The pair moves into the transmit register only at the start of a frame. If no new pair arrived, the previous one is sent again.

Slot n means the n-th bit-clock period (counted from 0) after the frame clock takes its left-channel level. Slots 0 to 31 form the left half and slots 32 to 63 the right half.

Top module: `audio_tx_port`

## Requirements
- R1: A channel sample is sent MSB first: within a half, data position k (0..23) carries sample bit 23-k.
- R2: With role_master=1, the bit clock spends 2 system clocks low and 2 high (period 4), and the frame clock has a period of 256 system clocks, changing only while the bit clock is low.
- R3: sdata_out changes only on the system-clock edge where the bit clock falls, so it is stable while the bit clock is high.
- R4: With fmt_i2s=0 (left-justified), the frame clock is high for the left channel and data position k equals slot k, so left bit 23 is in slot 0.
- R5: With fmt_i2s=1 (I2S), the frame clock is low for the left channel and data position k is sent in slot k+1, so slot 0 carries the last bit of the previous right half and left bit 23 is in slot 1.
- R6: The left sample occupies the first half of the frame and the right sample the second; data positions 24 to 31 of each half are driven 0.
- R7: load_ready is 1 while the holding register is empty; a pair is taken on a clock edge where load_valid and load_ready are both 1, load_ready is 0 from the next cycle, and it is 1 again once the pair has moved to the transmit register at the next frame start.
- R8: A frame that starts with the holding register empty retransmits the previous pair.
- R9: With role_master=0, sclk_out and lrck_out stay 0, and the data follows the external clocks: position advances by one on each falling edge of sclk_in and is driven within 4 system clocks of that edge.
- R10: In slave role, a change of lrck_in seen at a falling sclk_in edge restarts the position at slot 0 (left level) or slot 32 (right level), even when the previous half was shorter than 32 bits.
- R11: While rst_n is 0, sclk_out, lrck_out and sdata_out are 0 and load_ready is 1; the transmit register starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 x sample rate in master role |
| rst_n | input | 1 | Active-low synchronous reset |
| role_master | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| fmt_i2s | input | 1 | 0 = left-justified, 1 = I2S framing |
| sample_l | input | 24 | Left-channel sample to load |
| sample_r | input | 24 | Right-channel sample to load |
| load_valid | input | 1 | Sample pair on sample_l/sample_r is offered |
| load_ready | output | 1 | Holding register empty, pair will be taken |
| sclk_in | input | 1 | External bit clock (slave role) |
| lrck_in | input | 1 | External frame clock (slave role) |
| sclk_out | output | 1 | Generated bit clock (master role) |
| lrck_out | output | 1 | Generated frame clock (master role) |
| sdata_out | output | 1 | Serial audio data, changes on bit-clock fall |

## Verification
The bench decodes every bit at the bit-clock rising edge and compares it with a model of both framings, so a one-slot error in the I2S delay or a swapped frame-clock polarity shows up as a wrong MSB in slot 0 or 1. All-ones samples expose a design that sends sample bits instead of zeros in positions 24 to 31. Frames with no load catch a design that clears or garbles the pair instead of repeating it, and a check that load_ready rises again at the frame start catches a holding register that never empties. In slave role, a shortened left half and a shortened right half check realignment: a design that only counts bits would go on sending from the wrong position after such a half.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int SAMPLE_W  = 24;              // bits per channel sample
    localparam int SLOT_LOG2 = 6;               // log2 of bit periods per frame
    localparam int HALF_W    = SLOT_LOG2 - 1;   // index width within a half

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    // Bit carried in a given slot of the frame for the chosen framing.
    function automatic logic slot_bit(input logic [SLOT_LOG2-1:0] slot,
                                      input logic                 i2s,
                                      input pair_t                pr);
        logic [SLOT_LOG2-1:0] pos;
        logic [HALF_W-1:0]    idx;
        logic [SAMPLE_W-1:0]  word;
        pos  = i2s ? (slot - SLOT_LOG2'(1)) : slot;
        idx  = pos[HALF_W-1:0];
        word = pos[SLOT_LOG2-1] ? pr.right : pr.left;
        if (int'(idx) >= SAMPLE_W) begin
            return 1'b0;
        end
        return word[SAMPLE_W-1-int'(idx)];
    endfunction

endpackage

// File: rtl/audio_tx_mclk_div.sv
module audio_tx_mclk_div #(
    parameter int DIV_LOG2  = 2,
    parameter int SLOT_LOG2 = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 i2s,
    output logic                 sclk,
    output logic                 lrck,
    output logic [SLOT_LOG2-1:0] slot,
    output logic                 frame_begin
);
    localparam int CNT_W = DIV_LOG2 + SLOT_LOG2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             lrck;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (enable) begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end else begin
            div_d.cnt = '0;
        end
        div_d.sclk = enable & div_d.cnt[DIV_LOG2-1];
        div_d.lrck = enable & (div_d.cnt[CNT_W-1] ^ ~i2s);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign sclk        = div_q.sclk;
    assign lrck        = div_q.lrck;
    assign slot        = div_q.cnt[CNT_W-1:DIV_LOG2];
    assign frame_begin = enable & (&div_q.cnt);

    // R2: frame clock moves only while the bit clock is low
    p_lrck_at_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable && $past(enable) && $stable(i2s) && !$stable(lrck) |-> !sclk);

    // R2: bit clock high phase lasts exactly two system clocks
    p_sclk_high_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable && $past(enable) && $rose(sclk) |=> sclk ##1 !sclk);

endmodule

// File: rtl/audio_tx_clk_follow.sv
module audio_tx_clk_follow #(
    parameter int SLOT_LOG2   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 i2s,
    input  logic                 sclk_ext,
    input  logic                 lrck_ext,
    output logic [SLOT_LOG2-1:0] slot,
    output logic                 frame_begin
);
    localparam int SH_W = SYNC_STAGES + 1;
    localparam logic [SLOT_LOG2-1:0] HALF_SLOT = {1'b1, {(SLOT_LOG2-1){1'b0}}};

    typedef struct packed {
        logic [SH_W-1:0]      sclk_sh;
        logic [SH_W-1:0]      lrck_sh;
        logic                 lr_seen;
        logic [SLOT_LOG2-1:0] slot;
    } fol_t;

    fol_t fol_d, fol_q;

    logic sclk_fall;
    logic lr_now;
    logic lr_chg;
    logic left_now;

    always_comb begin
        sclk_fall = fol_q.sclk_sh[SYNC_STAGES] & ~fol_q.sclk_sh[SYNC_STAGES-1];
        lr_now    = fol_q.lrck_sh[SYNC_STAGES-1];
        lr_chg    = lr_now ^ fol_q.lr_seen;
        left_now  = lr_now ^ i2s;
    end

    always_comb begin
        fol_d         = fol_q;
        fol_d.sclk_sh = {fol_q.sclk_sh[SH_W-2:0], sclk_ext};
        fol_d.lrck_sh = {fol_q.lrck_sh[SH_W-2:0], lrck_ext};
        if (enable && sclk_fall) begin
            fol_d.lr_seen = lr_now;
            if (lr_chg) begin
                fol_d.slot = left_now ? '0 : HALF_SLOT;
            end else begin
                fol_d.slot = fol_q.slot + SLOT_LOG2'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fol_q <= '0;
        end else begin
            fol_q <= fol_d;
        end
    end

    assign slot        = fol_q.slot;
    assign frame_begin = enable & sclk_fall & lr_chg & left_now;

    // R10: a frame-clock change restarts at a half boundary
    p_realign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enable && sclk_fall && lr_chg |=> (fol_q.slot == '0) || (fol_q.slot == HALF_SLOT));

    // R9: each bit-clock fall without frame change moves one slot on
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enable && sclk_fall && !lr_chg |=>
            fol_q.slot == SLOT_LOG2'($past(fol_q.slot) + SLOT_LOG2'(1)));

    // R9: slot is frozen between bit-clock falls
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(fol_q.slot));

endmodule

// File: rtl/audio_tx_port.sv
module audio_tx_port
    import audio_tx_pkg::*;
#(
    parameter int DIV_LOG2    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                role_master,
    input  logic                fmt_i2s,
    input  logic [SAMPLE_W-1:0] sample_l,
    input  logic [SAMPLE_W-1:0] sample_r,
    input  logic                load_valid,
    output logic                load_ready,
    input  logic                sclk_in,
    input  logic                lrck_in,
    output logic                sclk_out,
    output logic                lrck_out,
    output logic                sdata_out
);
    typedef struct packed {
        pair_t hold;
        logic  hold_full;
        pair_t live;
    } port_t;

    port_t st_d, st_q;

    logic [SLOT_LOG2-1:0] m_slot, s_slot, slot;
    logic                 m_begin, s_begin, frame_begin;

    audio_tx_mclk_div #(
        .DIV_LOG2  (DIV_LOG2),
        .SLOT_LOG2 (SLOT_LOG2)
    ) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (role_master),
        .i2s         (fmt_i2s),
        .sclk        (sclk_out),
        .lrck        (lrck_out),
        .slot        (m_slot),
        .frame_begin (m_begin)
    );

    audio_tx_clk_follow #(
        .SLOT_LOG2   (SLOT_LOG2),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_follow (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (~role_master),
        .i2s         (fmt_i2s),
        .sclk_ext    (sclk_in),
        .lrck_ext    (lrck_in),
        .slot        (s_slot),
        .frame_begin (s_begin)
    );

    always_comb begin
        slot        = role_master ? m_slot  : s_slot;
        frame_begin = role_master ? m_begin : s_begin;
    end

    always_comb begin
        st_d = st_q;
        if (frame_begin && st_q.hold_full) begin
            st_d.live      = st_q.hold;
            st_d.hold_full = 1'b0;
        end
        if (load_valid && !st_q.hold_full) begin
            st_d.hold.left  = sample_l;
            st_d.hold.right = sample_r;
            st_d.hold_full  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_ready = ~st_q.hold_full;
    assign sdata_out  = slot_bit(slot, fmt_i2s, st_q.live);

    // R7: taking a pair closes the handshake on the next cycle
    p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid && load_ready |=> !load_ready);

    // R7: a full holding register stays full until a frame starts
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_ready && !frame_begin |=> !load_ready);

    // R3: in master role data moves only with a falling bit clock
    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        role_master && $past(role_master) && $stable(fmt_i2s) && !$stable(sdata_out)
            |-> $fell(sclk_out));

    // R9: clock outputs idle in slave role
    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !role_master && $past(!role_master) |-> !sclk_out && !lrck_out);

endmodule

// File: tb/audio_tx_port_test.sv
module audio_tx_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        role_master = 1'b1;
    logic        fmt_i2s = 1'b0;
    logic [23:0] sample_l = '0;
    logic [23:0] sample_r = '0;
    logic        load_valid = 1'b0;
    logic        load_ready;
    logic        sclk_in = 1'b1;
    logic        lrck_in = 1'b0;
    logic        sclk_out, lrck_out, sdata_out;

    always #10 clk = ~clk;

    audio_tx_port uut (
        .clk(clk), .rst_n(rst_n), .role_master(role_master), .fmt_i2s(fmt_i2s),
        .sample_l(sample_l), .sample_r(sample_r), .load_valid(load_valid),
        .load_ready(load_ready), .sclk_in(sclk_in), .lrck_in(lrck_in),
        .sclk_out(sclk_out), .lrck_out(lrck_out), .sdata_out(sdata_out)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int slot, input bit i2s,
                                   input logic [23:0] l, input logic [23:0] r);
        int p;
        int k;
        logic [23:0] w;
        p = i2s ? (slot + 63) % 64 : slot;
        k = p % 32;
        w = (p < 32) ? l : r;
        if (k >= 24) return 1'b0;
        return w[23-k];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // monitor state, written only by the monitor process
    bit mon_en = 0;
    bit synced, last_lr, prev_sclk, prev_sdata, pend_full_b, acc_prev;
    bit have_frame, have_rise, repeat_frame, realign_flag;
    int slot_b, cyc, rise_cyc, frame_cyc;
    logic [23:0] pend_l, pend_r, act_l, act_r;

    always @(negedge clk) begin
        bit sc, lr, is_left;
        int pos;
        string tag;
        cyc++;
        if (!mon_en) begin
            synced = 0; last_lr = 0; prev_sclk = 0; prev_sdata = 0;
            pend_full_b = 0; acc_prev = 0; have_frame = 0; have_rise = 0;
            repeat_frame = 0; realign_flag = 0; slot_b = 0;
            act_l = '0; act_r = '0; pend_l = '0; pend_r = '0;
        end else begin
            sc = role_master ? sclk_out : sclk_in;
            lr = role_master ? lrck_out : lrck_in;
            if (acc_prev) check(!load_ready, "R7", load_ready, 0);
            acc_prev = 0;
            if (load_valid) begin
                check(load_ready, "R7", load_ready, 1);
                pend_l = sample_l; pend_r = sample_r;
                pend_full_b = 1; acc_prev = 1;
            end
            if (role_master && sc && prev_sclk && synced)
                check(sdata_out == prev_sdata, "R3", sdata_out, prev_sdata);
            if (sc && !prev_sclk) begin
                if (lr != last_lr) begin
                    is_left = lr ^ fmt_i2s;
                    realign_flag = synced && (slot_b != 31) && (slot_b != 63);
                    slot_b = is_left ? 0 : 32;
                    if (is_left) begin
                        if (role_master && have_frame)
                            check(cyc - frame_cyc == 256, "R2", cyc - frame_cyc, 256);
                        repeat_frame = have_frame && !pend_full_b;
                        if (pend_full_b) begin
                            check(load_ready, "R7", load_ready, 1);
                            act_l = pend_l; act_r = pend_r; pend_full_b = 0;
                        end
                        frame_cyc = cyc; have_frame = 1; synced = 1;
                    end
                    last_lr = lr;
                end else begin
                    slot_b = (slot_b + 1) % 64;
                end
                if (role_master && synced && have_rise)
                    check(cyc - rise_cyc == 4, "R2", cyc - rise_cyc, 4);
                rise_cyc = cyc; have_rise = synced;
                if (!role_master)
                    check(!sclk_out && !lrck_out, "R9", {sclk_out, lrck_out}, 0);
                if (synced) begin
                    pos = fmt_i2s ? (slot_b + 63) % 64 : slot_b;
                    if (pos % 32 >= 24) tag = "R6";
                    else if (realign_flag) tag = "R10";
                    else if (!role_master) tag = "R9";
                    else if (repeat_frame) tag = "R8";
                    else if (!fmt_i2s && slot_b == 0) tag = "R4";
                    else if (fmt_i2s && slot_b <= 1) tag = "R5";
                    else tag = "R1";
                    check(sdata_out == exp_bit(slot_b, fmt_i2s, act_l, act_r),
                          tag, sdata_out, exp_bit(slot_b, fmt_i2s, act_l, act_r));
                end
            end
            prev_sclk = sc;
            prev_sdata = sdata_out;
        end
    end

    task automatic loader(input int frames);
        for (int k = 0; k < frames; k++) begin
            wait (synced && slot_b == 8);
            if (k != 3 && k != 4 && (k == 0 || ($urandom % 4) != 0)) begin
                @(posedge clk); #2;
                sample_l = (k == 0) ? 24'hFFFFFF : 24'($urandom);
                sample_r = (k == 0) ? 24'hFFFFFF : 24'($urandom);
                load_valid = 1'b1;
                @(posedge clk); #2;
                load_valid = 1'b0;
            end
            wait (slot_b != 8);
        end
    endtask

    task automatic gen_half(input bit lvl, input int nbits);
        for (int b = 0; b < nbits; b++) begin
            sclk_in = 1'b0;
            if (b == 0) lrck_in = lvl;
            tick(8);
            sclk_in = 1'b1;
            tick(8);
        end
    endtask

    task automatic slave_frames(input int frames, input bit i2s);
        bit left_lvl;
        left_lvl = ~i2s;
        for (int f = 0; f < frames; f++) begin
            if (f == 2) begin
                gen_half(left_lvl, 32); gen_half(~left_lvl, 10);   // short right
            end else if (f == 3) begin
                gen_half(left_lvl, 12); gen_half(~left_lvl, 32);   // short left
            end else begin
                gen_half(left_lvl, 32); gen_half(~left_lvl, 32);
            end
        end
    endtask

    task automatic run_config(input bit master, input bit i2s, input int frames);
        mon_en = 0;
        rst_n = 1'b0;
        role_master = master;
        fmt_i2s = i2s;
        sclk_in = 1'b1;
        lrck_in = 1'b0;
        load_valid = 1'b0;
        tick(3);
        @(negedge clk);
        check(!sclk_out && !lrck_out && !sdata_out, "R11",
              {sclk_out, lrck_out, sdata_out}, 0);
        check(load_ready, "R11", load_ready, 1);
        @(posedge clk); #2;
        rst_n = 1'b1;
        mon_en = 1;
        if (master) begin
            loader(frames);
            tick(600);
        end else begin
            fork
                slave_frames(frames + 3, i2s);
                loader(frames);
            join
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        run_config(1'b1, 1'b0, 7);
        run_config(1'b1, 1'b1, 7);
        run_config(1'b0, 1'b0, 6);
        run_config(1'b0, 1'b1, 6);
        mon_en = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
            $finish;
        end
    end

endmodule